// File: doc/BRIEF.md
# Outbound Address Translation Window

This block sits between a local bus master and a PCIe transaction generator and turns a 32-bit local address into a 64-bit PCIe address. It holds a small set of programmable windows. Each window has a 64-bit PCIe base split into two 32-bit words, a size mask counted in 128-byte units, and a control word with an enable flag and a flag that marks the window as I/O space instead of memory space.

Each outbound request is compared against all enabled windows in the same cycle. The outputs give the translated address, the index of the selected window, the space type, and whether the request was a hit or a miss. Software programs the windows through a 32-bit register port. The usual sequence is to clear the control word, rewrite base and mask, and then enable the window again.

Top module: `owt_xlate`

## Requirements
- R1: After reset every register reads as zero, every window is disabled, and any request is a miss.
- R2: Register word index 4*w+k selects window w. k=0 is the low base word, k=1 the high base word, k=2 the mask (bits 31:7 stored, bits 6:0 read as zero), and k=3 the control word (bit 31 enable, bit 8 I/O space, other bits read as zero). Reads are combinational.
- R3: Let M = {mask[31:7], 7'h7f}. An enabled window matches a request address A when (A & ~M) equals (base_low & ~M).
- R4: On a hit, xaddr_o is {base_high, (base_low & ~M) | (A & M)}, so xaddr_o[6:0] always equals A[6:0].
- R5: On a hit, io_o equals the control bit 8 of the selected window. On a miss, io_o, win_o and xaddr_o are zero.
- R6: When several enabled windows match, the lowest-numbered one is selected on win_o.
- R7: A window with control bit 31 clear never matches, whatever its base and mask hold.
- R8: hit_o and miss_o are combinational with req_valid_i. A request that matches no window raises miss_o in that same cycle. Both outputs are low when req_valid_i is low, and they are never high together.
- R9: A register write takes effect from the clock edge that captures it. A request presented in the same cycle as the write is translated with the old contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| req_valid_i | input | 1 | Outbound request present |
| req_addr_i | input | 32 | Local request address |
| hit_o | output | 1 | Request matched a window |
| miss_o | output | 1 | Request matched no window |
| win_o | output | 2 | Index of the selected window |
| io_o | output | 1 | Selected window is I/O space |
| xaddr_o | output | 64 | Translated PCIe address |

## Verification
A register write and a translation can happen in the same cycle. The interesting case is a write that clears the enable of the window a live request is hitting. The bench holds the request steady, drives that write in the same cycle, and samples before the edge: it expects the old hit and the old translated address there. After the edge it expects a miss. Overlapping windows and a disabled window that covers a tested address also check priority and enable against the same request stream.

// File: rtl/owt_pkg.sv
package owt_pkg;
  localparam int MASK_LSB = 7;

  typedef struct packed {
    logic [31:0] base_lo;
    logic [31:0] base_hi;
    logic [31:0] mask;
    logic        en;
    logic        io;
  } win_cfg_t;
endpackage

// File: rtl/owt_regs.sv
module owt_regs
  import owt_pkg::*;
#(
  parameter int NUM_WIN = 4,
  localparam int AW = $clog2(NUM_WIN) + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  output win_cfg_t      cfg_o [NUM_WIN]
);
  logic [AW-3:0] sel_win;
  logic [1:0]    sel_fld;

  assign sel_win = addr_i[AW-1:2];
  assign sel_fld = addr_i[1:0];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_o[w] <= '0;
      end else if (we_i && sel_win == (AW-2)'(w)) begin
        case (sel_fld)
          2'd0: cfg_o[w].base_lo <= wdata_i;
          2'd1: cfg_o[w].base_hi <= wdata_i;
          2'd2: cfg_o[w].mask    <= {wdata_i[31:MASK_LSB], {MASK_LSB{1'b0}}};
          default: begin
            cfg_o[w].en <= wdata_i[31];
            cfg_o[w].io <= wdata_i[8];
          end
        endcase
      end
    end
  end

  always_comb begin
    case (sel_fld)
      2'd0:    rdata_o = cfg_o[sel_win].base_lo;
      2'd1:    rdata_o = cfg_o[sel_win].base_hi;
      2'd2:    rdata_o = cfg_o[sel_win].mask;
      default: rdata_o = {cfg_o[sel_win].en, 22'b0, cfg_o[sel_win].io, 8'b0};
    endcase
  end
endmodule

// File: rtl/owt_match.sv
module owt_match
  import owt_pkg::*;
(
  input  win_cfg_t    cfg_i,
  input  logic [31:0] addr_i,
  output logic        hit_o,
  output logic [63:0] xaddr_o
);
  logic [31:0] pass_m;

  assign pass_m  = {cfg_i.mask[31:MASK_LSB], {MASK_LSB{1'b1}}};
  assign hit_o   = cfg_i.en && (((addr_i ^ cfg_i.base_lo) & ~pass_m) == 32'd0);
  assign xaddr_o = {cfg_i.base_hi, (cfg_i.base_lo & ~pass_m) | (addr_i & pass_m)};
endmodule

// File: rtl/owt_prio.sv
module owt_prio #(
  parameter int NUM_WIN = 4,
  localparam int IW = $clog2(NUM_WIN)
) (
  input  logic [NUM_WIN-1:0] match_i,
  output logic [IW-1:0]      idx_o,
  output logic               any_o
);
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (match_i[i]) begin
        idx_o = IW'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/owt_xlate.sv
module owt_xlate
  import owt_pkg::*;
#(
  parameter int NUM_WIN = 4,
  localparam int AW = $clog2(NUM_WIN) + 2,
  localparam int IW = $clog2(NUM_WIN)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  input  logic          req_valid_i,
  input  logic [31:0]   req_addr_i,
  output logic          hit_o,
  output logic          miss_o,
  output logic [IW-1:0] win_o,
  output logic          io_o,
  output logic [63:0]   xaddr_o
);
  win_cfg_t           cfg   [NUM_WIN];
  logic [63:0]        xaddr [NUM_WIN];
  logic [NUM_WIN-1:0] match_vec;
  logic [IW-1:0]      sel_idx;
  logic               any_hit;

  owt_regs #(.NUM_WIN(NUM_WIN)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .cfg_o   (cfg)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
    owt_match u_match (
      .cfg_i   (cfg[w]),
      .addr_i  (req_addr_i),
      .hit_o   (match_vec[w]),
      .xaddr_o (xaddr[w])
    );
  end

  owt_prio #(.NUM_WIN(NUM_WIN)) u_prio (
    .match_i (match_vec),
    .idx_o   (sel_idx),
    .any_o   (any_hit)
  );

  assign hit_o   = req_valid_i & any_hit;
  assign miss_o  = req_valid_i & ~any_hit;
  assign win_o   = hit_o ? sel_idx : '0;
  assign io_o    = hit_o & cfg[sel_idx].io;
  assign xaddr_o = hit_o ? xaddr[sel_idx] : 64'd0;
endmodule

// File: rtl/owt_xlate_chk.sv
module owt_xlate_chk #(
  parameter int NUM_WIN = 4,
  localparam int AW = $clog2(NUM_WIN) + 2,
  localparam int IW = $clog2(NUM_WIN)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               reg_we_i,
  input logic [AW-1:0]      reg_addr_i,
  input logic               wr_en_bit,
  input logic               req_valid_i,
  input logic [6:0]         req_lo,
  input logic               hit_o,
  input logic               miss_o,
  input logic [IW-1:0]      win_o,
  input logic [6:0]         xaddr_lo,
  input logic [NUM_WIN-1:0] match_vec
);
  p_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && miss_o));

  p_need_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o || miss_o) |-> req_valid_i);

  p_low_pass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (xaddr_lo == req_lo));

  p_lowest_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ((match_vec & ((NUM_WIN'(1) << win_o) - NUM_WIN'(1))) == '0));

  p_disable_next_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == AW'(3) && !wr_en_bit) |=> !(hit_o && win_o == '0));
endmodule

bind owt_xlate owt_xlate_chk #(.NUM_WIN(NUM_WIN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .wr_en_bit   (reg_wdata_i[31]),
  .req_valid_i (req_valid_i),
  .req_lo      (req_addr_i[6:0]),
  .hit_o       (hit_o),
  .miss_o      (miss_o),
  .win_o       (win_o),
  .xaddr_lo    (xaddr_o[6:0]),
  .match_vec   (match_vec)
);

// File: tb/tb_owt_xlate.sv
module tb_owt_xlate;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic        hit_o, miss_o, io_o;
  logic [1:0]  win_o;
  logic [63:0] xaddr_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  owt_xlate dut (.*);

  // {addr, hit, win, io, xaddr}
  localparam logic [99:0] VEC [8] = '{
    {32'h1000_0000, 1'b1, 2'd0, 1'b0, 64'h0000_0001_1000_0000},
    {32'h100F_FFFF, 1'b1, 2'd0, 1'b0, 64'h0000_0001_100F_FFFF},
    {32'h1010_0000, 1'b0, 2'd0, 1'b0, 64'h0},
    {32'h2000_1234, 1'b1, 2'd1, 1'b1, 64'h0000_00AA_2000_1234},
    {32'h2000_0ABC, 1'b1, 2'd1, 1'b1, 64'h0000_00AA_2000_0ABC},
    {32'h2001_0000, 1'b0, 2'd0, 1'b0, 64'h0},
    {32'h3000_0010, 1'b0, 2'd0, 1'b0, 64'h0},
    {32'h0FFF_FFFF, 1'b0, 2'd0, 1'b0, 64'h0}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input string req, input logic [3:0] a, input logic [31:0] exp);
    reg_addr_i = a;
    #1;
    check(req, {32'd0, reg_rdata_o}, {32'd0, exp});
  endtask

  task automatic req(input string tag, input logic [31:0] a, input logic h,
                     input logic [1:0] w, input logic io, input logic [63:0] x);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = a;
    #1;
    check({tag, " hit"}, {63'd0, hit_o}, {63'd0, h});
    check({tag, " miss"}, {63'd0, miss_o}, {63'd0, ~h});
    check({tag, " win"}, {62'd0, win_o}, {62'd0, w});
    check({tag, " io"}, {63'd0, io_o}, {63'd0, io});
    check({tag, " xaddr"}, xaddr_o, x);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #80000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #10;
    rst_ni = 1'b1;
    // R1: reset state
    for (int i = 0; i < 16; i++) rd("R1 reset read", 4'(i), 32'd0);
    req("R1 reset req", 32'h0000_0000, 1'b0, 2'd0, 1'b0, 64'd0);

    // program windows
    wr(4'd0, 32'h1000_0000); wr(4'd1, 32'h0000_0001); wr(4'd2, 32'h000F_FF80); wr(4'd3, 32'h8000_0000);
    wr(4'd4, 32'h2000_0000); wr(4'd5, 32'h0000_00AA); wr(4'd6, 32'h0000_FF80); wr(4'd7, 32'h8000_0100);
    wr(4'd8, 32'h2000_0000); wr(4'd9, 32'h0000_0002); wr(4'd10, 32'h0000_0F80); wr(4'd11, 32'h8000_0000);
    wr(4'd12, 32'h3000_0000); wr(4'd13, 32'hFFFF_FFFF); wr(4'd14, 32'h0000_0000); wr(4'd15, 32'h0000_0100);

    // R2: readback
    rd("R2 base_lo w1", 4'd4, 32'h2000_0000);
    rd("R2 base_hi w1", 4'd5, 32'h0000_00AA);
    rd("R2 ctrl w1", 4'd7, 32'h8000_0100);

    // vector walk: R3 R4 R5 R6 R7
    for (int v = 0; v < 8; v++)
      req($sformatf("R3/R4/R5/R6/R7 vec%0d", v), VEC[v][99:68], VEC[v][67],
          VEC[v][66:65], VEC[v][64], VEC[v][63:0]);

    // R8: no request -> neither flag
    @(negedge clk_i);
    req_valid_i = 1'b0; req_addr_i = 32'h1000_0000;
    #1;
    check("R8 idle hit", {63'd0, hit_o}, 64'd0);
    check("R8 idle miss", {63'd0, miss_o}, 64'd0);

    // R2: mask/ctrl unused bits read zero
    wr(4'd14, 32'hFFFF_FFFF);
    rd("R2 mask lsbs", 4'd14, 32'hFFFF_FF80);
    wr(4'd14, 32'h0000_0000);
    wr(4'd15, 32'hFFFF_FFFF);
    rd("R2 ctrl bits", 4'd15, 32'h8000_0100);

    // 128-byte window w3 enabled, I/O
    req("R4 w3 top", 32'h3000_007F, 1'b1, 2'd3, 1'b1, 64'hFFFF_FFFF_3000_007F);
    req("R3 w3 past", 32'h3000_0080, 1'b0, 2'd0, 1'b0, 64'd0);

    // R9: write and request in same cycle
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = 32'h3000_0010;
    reg_we_i = 1'b1; reg_addr_i = 4'd15; reg_wdata_i = 32'h0;
    #1;
    check("R9 old hit", {63'd0, hit_o}, 64'd1);
    check("R9 old xaddr", xaddr_o, 64'hFFFF_FFFF_3000_0010);
    @(negedge clk_i);
    reg_we_i = 1'b0;
    #1;
    check("R9 new miss", {63'd0, miss_o}, 64'd1);

    // R7: disable w0, base still held
    wr(4'd3, 32'h0000_0000);
    req("R7 w0 off", 32'h1000_0000, 1'b0, 2'd0, 1'b0, 64'd0);
    rd("R7 base kept", 4'd0, 32'h1000_0000);

    // R6: w1 off, w2 now wins overlap
    wr(4'd7, 32'h0000_0100);
    req("R6 w2 after w1 off", 32'h2000_0ABC, 1'b1, 2'd2, 1'b0, 64'h0000_0002_2000_0ABC);

    // R1: reset clears everything
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    rst_ni = 1'b1;
    rd("R1 re-reset ctrl", 4'd11, 32'd0);
    req("R1 re-reset req", 32'h2000_0ABC, 1'b0, 2'd0, 1'b0, 64'd0);

    finish_run();
  end
endmodule